// File: doc/BRIEF.md
# Timer Input Capture Unit

This block pairs a 16-bit up-counter with one capture channel. The counter advances on a tick from a prescaler, and software picks the divisor with a 3-bit clock-select field. A select code of zero halts the counter. The capture pin first passes through a two-stage synchronizer, then through a majority-free level filter that software can switch in. When the edge of the chosen polarity arrives, the unit copies the running count into a capture register, sets a capture flag, and can raise an interrupt.

Software reaches the unit through an 8-bit register port. Each 16-bit quantity, the running count and the captured value, is split into a low byte and a high byte. One shared holding byte keeps each multi-byte access coherent. Reading a low byte loads the matching high byte into the holding byte. Writing the high byte of the count fills the holding byte, and the later low-byte write moves both bytes into the counter at once. A typical use is timing a square wave: capture one edge, flip the polarity, capture the next edge, and subtract the two.

Top module: `icap_timer`

## Requirements
- R1: The count is 16 bits wide, gains 1 on every prescaler tick, and wraps from 0xFFFF to 0x0000.
- R2: A capture event stores the count into the capture register. With the filter off, a pin change driven between two clock edges stores the count held just after the second following rising clock edge.
- R3: CTRL bit 3 picks the capture polarity: 1 selects rising edges and 0 selects falling edges. An edge of the other polarity leaves the flag and the capture register unchanged.
- R4: CTRL bit 4 enables the filter. With the filter on, the filtered level changes only after 4 consecutive equal synchronized samples, so the stored count is 4 greater than with the filter off. A pulse shorter than 4 samples is not captured.
- R5: Every capture sets FLAGS bit 0. `cap_irq` is high exactly when that flag and IEN bit 0 are both 1.
- R6: A counter wrap sets FLAGS bit 1. `ovf_irq` is high exactly when that flag and IEN bit 1 are both 1.
- R7: CTRL bits 2:0 select the tick rate. Codes 1 to 5 divide the clock by 1, 8, 64, 256 and 1024. Codes 0, 6 and 7 stop the counter. A write to the count low byte restarts the prescaler phase, so the first tick comes a full divisor period later.
- R8: Register addresses are 0 CTRL, 1 IEN, 2 FLAGS, 3 count low, 4 count high, 5 capture low and 6 capture high. Reading a low byte returns the live low byte and, at that clock edge, copies the matching high byte into the holding byte. Reading either high-byte address returns the holding byte.
- R9: Writing the count high byte loads only the holding byte. Writing the count low byte loads the count with {holding byte, written byte}.
- R10: Writing 1 to a FLAGS bit clears that flag, and writing 0 leaves it unchanged. Pulsing `cap_ack` clears the capture flag. A flag that is set and cleared in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| cap_ack | input | 1 | Capture interrupt acknowledge, clears the capture flag |
| cap_irq | output | 1 | Capture interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
If the synchronizer or the filter is out of phase, the stored capture value is off by a fixed number of counts. This shows up on the first capture-register read after the pin toggles. A stale holding byte shows up as a torn count high byte, but only when the low byte is read just before a carry into the high byte. For that reason the bench reads across a 0xFE to 0x00 boundary. A broken prescaler phase shows up as a count that is off by one after a whole number of divisor periods. A missing flag or a wrong interrupt gate shows up at the interrupt pins within one cycle of the event.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_IEN    = 3'd1,
    A_FLAGS  = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4,
    A_CAP_LO = 3'd5,
    A_CAP_HI = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;

  // Divisor for a clock-select code; zero means the counter is halted.
  function automatic int unsigned prescale_div(input logic [2:0] sel);
    case (sel)
      3'd1:    return 1;
      3'd2:    return 8;
      3'd3:    return 64;
      3'd4:    return 256;
      3'd5:    return 1024;
      default: return 0;
    endcase
  endfunction

  // Sticky flag update: a set in the same cycle as a clear wins.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/icap_prescaler.sv
module icap_prescaler import icap_pkg::*; #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);
  int unsigned      div;
  logic             run;
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] last;

  always_comb begin
    div  = prescale_div(sel);
    run  = (div != 0);
    last = PRE_W'(div - 1);
    tick = run && !restart && (phase == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    phase <= '0;
    else if (restart || !run)      phase <= '0;
    else if (phase == last)        phase <= '0;
    else                           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/icap_input_cond.sv
module icap_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic filt_en,
  input  logic edge_rise,
  output logic level,
  output logic cap_event
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic                   sync_out;
  logic                   filt_q;
  logic                   prev_q;
  logic                   all_hi;
  logic                   all_lo;
  logic                   rise;
  logic                   fall;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      hist_q <= {hist_q[HIST_W-2:0], sync_out};
      if (all_hi)      filt_q <= 1'b1;
      else if (all_lo) filt_q <= 1'b0;
      prev_q <= level;
    end
  end

  always_comb begin
    all_hi    = sync_out && (&hist_q);
    all_lo    = !sync_out && !(|hist_q);
    level     = filt_en ? filt_q : sync_out;
    rise      = level && !prev_q;
    fall      = !level && prev_q;
    cap_event = edge_rise ? rise : fall;
  end
endmodule

// File: rtl/icap_count_core.sv
module icap_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cap_event,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic             wrap_evt
);
  assign wrap_evt = tick && !load && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      cap_val <= '0;
    end else begin
      if (load)      count <= load_val;
      else if (tick) count <= count + 1'b1;
      if (cap_event) cap_val <= count;
    end
  end
endmodule

// File: rtl/icap_timer.sv
module icap_timer import icap_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int PRE_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_ack,
  output logic              cap_irq,
  output logic              ovf_irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [2:0]        clk_sel;
  logic              edge_rise;
  logic              filt_en;
  logic              cap_ie;
  logic              ovf_ie;
  logic              cap_flag;
  logic              ovf_flag;
  logic [DATA_W-1:0] hold_q;

  logic              tick;
  logic              cnt_load;
  logic              cond_level;
  logic              cap_event;
  logic              wrap_evt;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap_val;

  logic wr_ctrl, wr_ien, wr_flags, wr_cnt_hi;
  logic rd_cnt_lo, rd_cap_lo;
  logic cap_clr, ovf_clr;

  always_comb begin
    wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    wr_ien    = bus_wr && (bus_addr == A_IEN);
    wr_flags  = bus_wr && (bus_addr == A_FLAGS);
    wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
    cnt_load  = bus_wr && (bus_addr == A_CNT_LO);
    rd_cnt_lo = bus_rd && (bus_addr == A_CNT_LO);
    rd_cap_lo = bus_rd && (bus_addr == A_CAP_LO);
    cap_clr   = (wr_flags && bus_wdata[0]) || cap_ack;
    ovf_clr   = wr_flags && bus_wdata[1];
  end

  icap_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel),
    .restart (cnt_load),
    .tick    (tick)
  );

  icap_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (cap_pin),
    .filt_en   (filt_en),
    .edge_rise (edge_rise),
    .level     (cond_level),
    .cap_event (cap_event)
  );

  icap_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (cnt_load),
    .load_val  ({hold_q, bus_wdata}),
    .cap_event (cap_event),
    .count     (count),
    .cap_val   (cap_val),
    .wrap_evt  (wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel   <= '0;
      edge_rise <= 1'b0;
      filt_en   <= 1'b0;
      cap_ie    <= 1'b0;
      ovf_ie    <= 1'b0;
      cap_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        clk_sel   <= bus_wdata[2:0];
        edge_rise <= bus_wdata[3];
        filt_en   <= bus_wdata[4];
      end
      if (wr_ien) begin
        cap_ie <= bus_wdata[0];
        ovf_ie <= bus_wdata[1];
      end
      cap_flag <= flag_next(cap_flag, cap_event, cap_clr);
      ovf_flag <= flag_next(ovf_flag, wrap_evt, ovf_clr);
      if (wr_cnt_hi)      hold_q <= bus_wdata;
      else if (rd_cnt_lo) hold_q <= count[CNT_W-1:DATA_W];
      else if (rd_cap_lo) hold_q <= cap_val[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = DATA_W'({filt_en, edge_rise, clk_sel});
      A_IEN:    bus_rdata = DATA_W'({ovf_ie, cap_ie});
      A_FLAGS:  bus_rdata = DATA_W'({ovf_flag, cap_flag});
      A_CNT_LO: bus_rdata = count[DATA_W-1:0];
      A_CAP_LO: bus_rdata = cap_val[DATA_W-1:0];
      A_CNT_HI,
      A_CAP_HI: bus_rdata = hold_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign cap_irq = cap_flag && cap_ie;
  assign ovf_irq = ovf_flag && ovf_ie;
endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clk_sel,
  input logic             tick,
  input logic             cnt_load,
  input logic             cap_event,
  input logic             wrap_evt,
  input logic             edge_rise,
  input logic             cond_level,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             ovf_flag,
  input logic             cap_irq,
  input logic             ovf_irq
);
  // R2
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> (cap_val == $past(count)));

  // R3
  cap_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |-> (cond_level == edge_rise));

  // R5
  cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> cap_flag);

  // R5
  cap_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> cap_flag);

  // R6
  ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf_flag && count == '0));

  // R6
  ovf_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag);

  // R7
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> !tick);

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_load) |=> $stable(count));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load) |=> (count == $past(count) + 1'b1));
endmodule

bind icap_timer icap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_sel    (clk_sel),
  .tick       (tick),
  .cnt_load   (cnt_load),
  .cap_event  (cap_event),
  .wrap_evt   (wrap_evt),
  .edge_rise  (edge_rise),
  .cond_level (cond_level),
  .count      (count),
  .cap_val    (cap_val),
  .cap_flag   (cap_flag),
  .ovf_flag   (ovf_flag),
  .cap_irq    (cap_irq),
  .ovf_irq    (ovf_irq)
);

// File: tb/icap_timer_tb.sv
`timescale 1ns/1ps
module icap_timer_tb;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_IEN = 3'd1, AD_FLAGS = 3'd2,
                         AD_CLO = 3'd3, AD_CHI = 3'd4, AD_PLO = 3'd5, AD_PHI = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_pin = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_ack = 1'b0;
  logic       cap_irq;
  logic       ovf_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  icap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_ack(cap_ack), .cap_irq(cap_irq), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling clock edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_count(input logic [15:0] v);
    wr(AD_CHI, v[15:8]);
    wr(AD_CLO, v[7:0]);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(AD_CTRL, d);  check("R7 reset ctrl", {8'h0, d}, 16'h0000);
    rd(AD_CLO, d);   check("R1 reset count", {8'h0, d}, 16'h0000);
    wait_n(5);
    rd(AD_CLO, d);   check("R7 stopped at reset", {8'h0, d}, 16'h0000);
    rd(AD_FLAGS, d); check("R5 reset flags", {8'h0, d}, 16'h0000);
    check("R5 reset irq", {14'h0, cap_irq, ovf_irq}, 16'h0000);
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    wr(AD_CTRL, 8'h02);
    set_count(16'h0000);
    wait_n(80);
    rd(AD_CLO, d);   check("R7 div8", {8'h0, d}, 16'h000A);
    wr(AD_CTRL, 8'h03);
    set_count(16'h0000);
    wait_n(128);
    rd(AD_CLO, d);   check("R7 div64", {8'h0, d}, 16'h0002);
    wr(AD_CTRL, 8'h00);
    set_count(16'h0055);
    wait_n(20);
    rd(AD_CLO, d);   check("R7 stop code", {8'h0, d}, 16'h0055);
  endtask

  task automatic t_read_order();
    logic [7:0] lo, hi;
    wr(AD_CTRL, 8'h01);
    set_count(16'h12FE);
    rd(AD_CLO, lo);
    wait_n(3);
    rd(AD_CHI, hi);
    check("R8 coherent pair", {hi, lo}, 16'h12FE);
    rd(AD_CLO, lo);
    rd(AD_CHI, hi);
    check("R9 loaded count advanced", {hi, lo}, 16'h1303);
  endtask

  task automatic t_capture_rise();
    logic [7:0] lo, hi, f;
    wr(AD_FLAGS, 8'h03);
    wr(AD_CTRL, 8'h09);
    set_count(16'h00F0);
    cap_pin = 1'b1;
    wait_n(4);
    rd(AD_PLO, lo);
    rd(AD_PHI, hi);
    check("R2 capture value", {hi, lo}, 16'h00F2);
    rd(AD_FLAGS, f);
    check("R5 capture flag", {8'h0, f}, 16'h0001);
    check("R5 irq masked", {15'h0, cap_irq}, 16'h0000);
  endtask

  task automatic t_edge_select();
    logic [7:0] lo, hi, f;
    wr(AD_FLAGS, 8'h01);
    cap_pin = 1'b0;
    wait_n(6);
    rd(AD_FLAGS, f);
    check("R3 falling ignored in rise mode", {8'h0, f}, 16'h0000);
    rd(AD_PLO, lo);
    check("R3 capture kept", {8'h0, lo}, 16'h00F2);
    wr(AD_CTRL, 8'h01);
    cap_pin = 1'b1;
    wait_n(6);
    rd(AD_FLAGS, f);
    check("R3 rising ignored in fall mode", {8'h0, f}, 16'h0000);
    set_count(16'h0200);
    cap_pin = 1'b0;
    wait_n(4);
    rd(AD_PLO, lo);
    rd(AD_PHI, hi);
    check("R3 falling capture", {hi, lo}, 16'h0202);
  endtask

  task automatic t_filter();
    logic [7:0] lo, hi, f;
    wr(AD_CTRL, 8'h19);
    wait_n(6);
    wr(AD_FLAGS, 8'h01);
    cap_pin = 1'b1;
    wait_n(3);
    cap_pin = 1'b0;
    wait_n(10);
    rd(AD_FLAGS, f);
    check("R4 short pulse rejected", {8'h0, f}, 16'h0000);
    set_count(16'h0300);
    cap_pin = 1'b1;
    wait_n(8);
    rd(AD_PLO, lo);
    rd(AD_PHI, hi);
    check("R4 filtered capture delay", {hi, lo}, 16'h0306);
  endtask

  task automatic t_irq_and_clear();
    logic [7:0] f;
    wr(AD_IEN, 8'h01);
    check("R5 cap_irq raised", {15'h0, cap_irq}, 16'h0001);
    cap_ack = 1'b1;
    @(negedge clk);
    cap_ack = 1'b0;
    check("R10 ack clears irq", {15'h0, cap_irq}, 16'h0000);
    wr(AD_CTRL, 8'h01);
    cap_pin = 1'b0;
    wait_n(6);
    rd(AD_FLAGS, f);
    check("R5 flag set again", {8'h0, f}, 16'h0001);
    wr(AD_FLAGS, 8'h00);
    rd(AD_FLAGS, f);
    check("R10 write zero keeps flag", {8'h0, f}, 16'h0001);
    wr(AD_FLAGS, 8'h01);
    rd(AD_FLAGS, f);
    check("R10 write one clears flag", {8'h0, f}, 16'h0000);
    wr(AD_IEN, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    wr(AD_FLAGS, 8'h03);
    wr(AD_IEN, 8'h02);
    wr(AD_CTRL, 8'h01);
    set_count(16'hFFF0);
    wait_n(14);
    check("R6 no flag before wrap", {15'h0, ovf_irq}, 16'h0000);
    wait_n(3);
    check("R6 ovf_irq after wrap", {15'h0, ovf_irq}, 16'h0001);
    rd(AD_CLO, d);
    check("R1 wrapped count", {8'h0, d}, 16'h0001);
    rd(AD_FLAGS, d);
    check("R6 overflow flag", {8'h0, d}, 16'h0002);
    wr(AD_FLAGS, 8'h02);
    check("R10 overflow cleared", {15'h0, ovf_irq}, 16'h0000);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_read_order();
    t_capture_rise();
    t_edge_select();
    t_filter();
    t_irq_and_clear();
    t_overflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule